// File: doc/BRIEF.md
# Core Timer with Power-On Hold-Off

This block is a free-running counter chain that advances on every internal bus clock. It serves two purposes. Software reads a slow 8-bit tick count from it, and it raises an overflow interrupt at a fixed period. The same chain also measures how long the system reset is held after power-up.

While the power-on input is high, the chain stays at zero, the reset-release output stays low and the delay choice is captured. Once power-on drops, the chain starts counting at once, even though reset is still held. When the selected hold-off has elapsed (16 or 4064 clocks), the reset-release output goes high. On that same edge the chain is zeroed again, so the visible count starts fresh as the processor leaves reset.

The visible count is the chain divided by four. Each time the count wraps from 255 to 0, which is every 1024 clocks, a sticky flag is set and a one-cycle tick is sent to a downstream watchdog stage. The interrupt output is the flag gated by an enable input. All pins are plain control and status signals, so there is no handshake.

Top module: `ctmr_core`

## Requirements
- R1: While `por` is high, on the cycle after each clock edge `count` reads 0, `rst_n_out` is 0, `wdt_tick` is 0 and `irq` is 0.
- R2: `rst_n_out` rises on exactly the Nth rising edge on which `por` is sampled low. N is 16 when `dly_long` was 0 during power-on and 4064 when it was 1. Once high, it stays high until `por` rises again.
- R3: On the cycle in which `rst_n_out` first reads 1, `count` reads 0 because the chain has been cleared a second time.
- R4: After release, `count` equals floor(k/4) mod 256, where k is the number of edges since the release edge. It advances by one every 4 clocks and wraps from 255 to 0.
- R5: `wdt_tick` is high for exactly the one cycle after each edge on which `count` wraps to 0. That is when k is a nonzero multiple of 1024.
- R6: A flag is set when the count wraps. It is cleared by `flag_clr` on an edge with no wrap. If a wrap and a clear fall on the same edge, the set wins. `irq` equals the flag ANDed with `irq_en`.
- R7: `dly_long` is only captured while `por` is high. Changing it after `por` falls does not alter the hold-off length.
- R8: While `rst_n_out` is 0, neither `wdt_tick` nor `irq` is ever asserted, even when the chain passes a wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| por | input | 1 | Power-on level; high clears the chain and holds reset |
| dly_long | input | 1 | Hold-off select captured during power-on (0: 16, 1: 4064 clocks) |
| irq_en | input | 1 | Overflow interrupt enable |
| flag_clr | input | 1 | Clears the overflow flag on the next edge |
| irq | output | 1 | Overflow flag AND enable |
| rst_n_out | output | 1 | Reset release; 0 while the system is held in reset |
| count | output | 8 | Visible timer count (chain divided by 4) |
| wdt_tick | output | 1 | One-cycle pulse on each count wrap, for a watchdog stage |

## Verification
Suppose the phase state or the captured delay choice is wrong. Then `rst_n_out` rises at the wrong edge or not at all, and this shows up within 16 or 4064 cycles of power-on dropping. Suppose instead the chain misses its second clear. Then `count` reads nonzero in the release cycle, and every later wrap tick is shifted by that offset. A wrong flag state shows on `irq` in the cycle after a wrap or a clear, and the bench forces a clear onto a wrap edge so that the set-over-clear priority is exposed.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_RUN  = 1'b1
  } ctmr_phase_e;
endpackage

// File: rtl/ctmr_chain.sv
module ctmr_chain #(
  parameter int CHAIN_W = 12
) (
  input  logic               clk,
  input  logic               clr,
  output logic [CHAIN_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (clr) value <= '0;
    else     value <= value + 1'b1;
  end
endmodule

// File: rtl/ctmr_poweron.sv
module ctmr_poweron
  import ctmr_pkg::*;
#(
  parameter int CHAIN_W   = 12,
  parameter int DLY_SHORT = 16,
  parameter int DLY_LONG  = 4064
) (
  input  logic               clk,
  input  logic               por,
  input  logic               dly_long,
  input  logic [CHAIN_W-1:0] chain,
  output logic               release_now,
  output logic               held
);
  localparam logic [CHAIN_W-1:0] LAST_SHORT = CHAIN_W'(DLY_SHORT - 1);
  localparam logic [CHAIN_W-1:0] LAST_LONG  = CHAIN_W'(DLY_LONG - 1);

  ctmr_phase_e        phase;
  logic               sel_q;
  logic [CHAIN_W-1:0] last_cnt;

  // Delay choice is latched only during power-on.
  always_ff @(posedge clk) begin
    if (por) sel_q <= dly_long;
  end

  assign last_cnt    = sel_q ? LAST_LONG : LAST_SHORT;
  assign release_now = (phase == PH_HOLD) && !por && (chain == last_cnt);
  assign held        = (phase == PH_HOLD);

  always_ff @(posedge clk) begin
    if (por)              phase <= PH_HOLD;
    else if (release_now) phase <= PH_RUN;
  end
endmodule

// File: rtl/ctmr_ovf.sv
module ctmr_ovf #(
  parameter int WRAP_BITS = 10
) (
  input  logic                 clk,
  input  logic                 por,
  input  logic                 held,
  input  logic [WRAP_BITS-1:0] low_bits,
  input  logic                 flag_clr,
  input  logic                 irq_en,
  output logic                 flag_q,
  output logic                 tick,
  output logic                 irq
);
  logic wrap;

  // The next edge takes the low bits from all ones to zero.
  assign wrap = !held && (&low_bits);

  always_ff @(posedge clk) begin
    if (por) begin
      tick   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      tick <= wrap;
      if (held)          flag_q <= 1'b0;
      else if (wrap)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & irq_en;
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core #(
  parameter int COUNT_W   = 8,
  parameter int PRE_LOG2  = 2,
  parameter int CHAIN_W   = 12,
  parameter int DLY_SHORT = 16,
  parameter int DLY_LONG  = 4064
) (
  input  logic               clk,
  input  logic               por,
  input  logic               dly_long,
  input  logic               irq_en,
  input  logic               flag_clr,
  output logic               irq,
  output logic               rst_n_out,
  output logic [COUNT_W-1:0] count,
  output logic               wdt_tick
);
  localparam int WRAP_BITS = PRE_LOG2 + COUNT_W;

  logic [CHAIN_W-1:0] chain;
  logic               release_now;
  logic               held;
  logic               flag_q;
  logic               chain_clr;

  assign chain_clr = por | release_now;

  ctmr_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk   (clk),
    .clr   (chain_clr),
    .value (chain)
  );

  ctmr_poweron #(
    .CHAIN_W   (CHAIN_W),
    .DLY_SHORT (DLY_SHORT),
    .DLY_LONG  (DLY_LONG)
  ) u_por (
    .clk         (clk),
    .por         (por),
    .dly_long    (dly_long),
    .chain       (chain),
    .release_now (release_now),
    .held        (held)
  );

  ctmr_ovf #(.WRAP_BITS(WRAP_BITS)) u_ovf (
    .clk      (clk),
    .por      (por),
    .held     (held),
    .low_bits (chain[WRAP_BITS-1:0]),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .flag_q   (flag_q),
    .tick     (wdt_tick),
    .irq      (irq)
  );

  assign count     = chain[WRAP_BITS-1:PRE_LOG2];
  assign rst_n_out = !held;
endmodule

// File: rtl/ctmr_core_chk.sv
module ctmr_core_chk #(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               por,
  input logic               rst_n_out,
  input logic [COUNT_W-1:0] count,
  input logic               wdt_tick,
  input logic               irq,
  input logic               irq_en,
  input logic               flag_clr,
  input logic               flag_q
);
  logic seen_por = 1'b0;
  always_ff @(posedge clk) begin
    if (por) seen_por <= 1'b1;
  end

  p_por_clear_r1: assert property (@(posedge clk) disable iff (!seen_por)
    por |=> (count == '0 && !rst_n_out && !wdt_tick && !irq));

  p_rst_stays_r2: assert property (@(posedge clk) disable iff (!seen_por)
    (rst_n_out && !por) |=> rst_n_out);

  p_release_zero_r3: assert property (@(posedge clk) disable iff (!seen_por)
    $rose(rst_n_out) |-> (count == '0));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!seen_por || por)
    (rst_n_out && $past(rst_n_out)) |->
      (count == $past(count) || count == $past(count) + 1'b1));

  p_tick_wrap_r5: assert property (@(posedge clk) disable iff (!seen_por)
    wdt_tick |-> (count == '0 && rst_n_out));

  p_tick_single_r5: assert property (@(posedge clk) disable iff (!seen_por)
    wdt_tick |=> !wdt_tick);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!seen_por)
    irq |-> (irq_en && flag_q));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!seen_por)
    (flag_q && !flag_clr && !por && rst_n_out) |=> flag_q);

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!seen_por)
    !rst_n_out |-> (!wdt_tick && !irq));
endmodule

bind ctmr_core ctmr_core_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk       (clk),
  .por       (por),
  .rst_n_out (rst_n_out),
  .count     (count),
  .wdt_tick  (wdt_tick),
  .irq       (irq),
  .irq_en    (irq_en),
  .flag_clr  (flag_clr),
  .flag_q    (flag_q)
);

// File: tb/ctmr_core_test.sv
`timescale 1ns/1ps
module ctmr_core_test;
  logic       clk = 1'b0;
  logic       por = 1'b0;
  logic       dly_long = 1'b0;
  logic       irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       irq;
  logic       rst_n_out;
  logic [7:0] count;
  logic       wdt_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctmr_core uut (
    .clk       (clk),
    .por       (por),
    .dly_long  (dly_long),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .irq       (irq),
    .rst_n_out (rst_n_out),
    .count     (count),
    .wdt_tick  (wdt_tick)
  );

  function automatic int exp_count(int k);
    return (k / 4) % 256;
  endfunction

  function automatic bit exp_tick(int k);
    return (k > 0) && (k % 1024 == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One rising edge, then back to the falling edge for sampling and driving.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_por_state();
    chk(count == 8'd0, "R1 count", int'(count), 0);
    chk(rst_n_out == 1'b0, "R1 rst_n_out", int'(rst_n_out), 0);
    chk(wdt_tick == 1'b0, "R1 wdt_tick", int'(wdt_tick), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
  endtask

  task automatic wait_release(input int n, input bit quiet_chk);
    for (int i = 1; i <= n; i++) begin
      step();
      chk(rst_n_out == (i == n), "R2 release edge", int'(rst_n_out), int'(i == n));
      if (i == n)
        chk(count == 8'd0, "R3 count zero at release", int'(count), 0);
      if (quiet_chk && i < n) begin
        chk(wdt_tick == 1'b0, "R8 no tick while held", int'(wdt_tick), 0);
        chk(irq == 1'b0, "R8 no irq while held", int'(irq), 0);
      end
    end
  endtask

  task automatic run_released(input int n);
    int  k = 0;
    bit  mflag = 1'b0;
    bit  forced = 1'b0;
    for (int i = 0; i < n; i++) begin
      irq_en   = 1'($urandom % 2);
      flag_clr = (($urandom % 8) == 0);
      if (((k + 1) % 1024 == 0) && !forced) begin
        flag_clr = 1'b1;   // R6 collision: clear on the wrap edge
        forced = 1'b1;
      end
      step();
      k++;
      if (k % 1024 == 0) mflag = 1'b1;
      else if (flag_clr) mflag = 1'b0;
      chk(count == 8'(exp_count(k)), "R4 count", int'(count), exp_count(k));
      chk(wdt_tick == exp_tick(k), "R5 wdt_tick", int'(wdt_tick), int'(exp_tick(k)));
      chk(irq == (mflag && irq_en), "R6 irq", int'(irq), int'(mflag && irq_en));
      chk(rst_n_out == 1'b1, "R2 stays released", int'(rst_n_out), 1);
    end
    flag_clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // Power-on with the short delay; toggle the select before it settles.
    por = 1'b1;
    dly_long = 1'b1;
    step();
    dly_long = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check_por_state();
    end
    // Drop power-on and flip the select afterwards (R7).
    por = 1'b0;
    dly_long = 1'b1;
    wait_release(16, 1'b1);
    run_released(3000);

    // Second power-on: long delay with the interrupt enabled.
    irq_en = 1'b1;
    por = 1'b1;
    dly_long = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check_por_state();
    end
    por = 1'b0;
    dly_long = 1'b0;   // R7: ignored after power-on
    wait_release(4064, 1'b1);
    run_released(1100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule